// File: doc/BRIEF.md
# Sequential Next-Block Prefetcher

This unit watches the stream of demand block addresses that a cache presents and looks for unit-stride runs. A run is recognised when an access lands exactly one block above the access before it. On that access the unit predicts the block after the current one and requests it early. The fill then arrives before first use, so a block the program has never touched can still hit. An access that does not extend a run starts a fresh candidate run and raises no request. This keeps mispredicted fills from pushing out useful lines when the access pattern is not sequential.

Blocks are 16 bytes, so the low four address bits are the byte offset and play no part in the arithmetic. A candidate goes through two filters before it is offered. First, a probe port asks the cache whether the block is already resident. Second, the candidate is compared with the last block this unit handed out. Only one request is in flight at a time. Runs that arrive while the request path is busy are discarded rather than queued.

Two state machines make up the unit. The run tracker has the states TRK_EMPTY, TRK_SEEN and TRK_RUN:
- A valid access moves it from TRK_EMPTY to TRK_SEEN.
- From TRK_SEEN or TRK_RUN, an access one block up goes to TRK_RUN and fires a trigger.
- Any other access goes to TRK_SEEN.

The issuer has the states ISS_IDLE, ISS_PROBE and ISS_OFFER:
- A trigger seen in ISS_IDLE latches the target and moves to ISS_PROBE.
- ISS_PROBE goes back to ISS_IDLE when the probe reports the block present or the target repeats the last issued block. Otherwise it goes to ISS_OFFER.
- ISS_OFFER holds until `pf_ready`, then records the issued block and returns to ISS_IDLE.

Top module: `seq_prefetch`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `pf_valid` and `probe_valid` are low.
- R2: An access triggers only when its block address (address bits 31:4) equals the block address of the previous valid access plus one, modulo 2^28. The first access after reset, a repeat of the same block, a backward step and any larger jump do not trigger.
- R3: The prefetch target is the triggering block plus one. `probe_addr` and `pf_addr` carry the target with bits 3:0 zero, and the offset bits of `acc_addr` have no effect.
- R4: A trigger accepted at a clock edge raises `probe_valid` for exactly the next cycle, with `probe_addr` equal to the target. If `probe_present` is high in that cycle, the candidate is discarded and `pf_valid` stays low.
- R5: A candidate whose block equals the block of the most recent completed request (`pf_valid` and `pf_ready` both high) is discarded without being offered.
- R6: At most one candidate is in flight. A trigger that arrives while a probe or an offer is pending, including the cycle in which the offer completes, is dropped.
- R7: Once `pf_valid` is high, it stays high with `pf_addr` unchanged until a cycle in which `pf_ready` is high.
- R8: The block arithmetic wraps: a run ending at block 0xFFFFFFE prefetches address 0xFFFFFFF0, one ending at 0xFFFFFFF prefetches address 0x00000000, and an access to block 0 after block 0xFFFFFFF counts as a unit step.
- R9: When a candidate is not discarded, `pf_valid` rises in the second cycle after the edge that accepted the trigger, directly after the probe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Demand access present this cycle |
| acc_addr | input | 32 | Byte address of the demand access |
| probe_valid | output | 1 | Residency query for the candidate block |
| probe_addr | output | 32 | Block-aligned address being queried |
| probe_present | input | 1 | Cache reports the queried block resident |
| pf_valid | output | 1 | Prefetch request offered |
| pf_ready | input | 1 | Request accepted this cycle |
| pf_addr | output | 32 | Block-aligned prefetch address |

## Verification
A tracker holding the wrong previous block shows up as a missing or spurious probe one cycle after the access that should or should not have triggered. That is the earliest point at which any port can reveal it. A wrong target, a lost duplicate record or a stale busy flag shows up on `probe_addr` and `pf_valid` within two cycles of the trigger. A broken hold shows up as `pf_addr` moving during a stall. The bench compares every output on every cycle against a model of the requirements, so any such fault is reported in the cycle it first becomes visible.

// File: rtl/seq_pf_pkg.sv
package seq_pf_pkg;

    typedef enum logic [1:0] {
        TRK_EMPTY = 2'd0,
        TRK_SEEN  = 2'd1,
        TRK_RUN   = 2'd2
    } trk_state_e;

    typedef enum logic [1:0] {
        ISS_IDLE  = 2'd0,
        ISS_PROBE = 2'd1,
        ISS_OFFER = 2'd2
    } iss_state_e;

endpackage

// File: rtl/seq_pf_tracker.sv
module seq_pf_tracker
    import seq_pf_pkg::*;
#(
    parameter int BLK_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [BLK_W-1:0] in_blk,
    output logic             trig,
    output logic [BLK_W-1:0] trig_target
);

    localparam logic [BLK_W-1:0] ONE_BLK = BLK_W'(1);

    trk_state_e       state_q, state_d;
    logic [BLK_W-1:0] last_q;
    logic             step_ok;

    assign step_ok = (in_blk == (last_q + ONE_BLK));

    // State register and last-block register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRK_EMPTY;
            last_q  <= '0;
        end else begin
            state_q <= state_d;
            if (in_valid) begin
                last_q <= in_blk;
            end
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        if (in_valid) begin
            unique case (state_q)
                TRK_EMPTY: state_d = TRK_SEEN;
                TRK_SEEN:  state_d = step_ok ? TRK_RUN : TRK_SEEN;
                TRK_RUN:   state_d = step_ok ? TRK_RUN : TRK_SEEN;
                default:   state_d = TRK_EMPTY;
            endcase
        end
    end

    // Outputs: a trigger on every access that extends a run.
    always_comb begin
        trig        = in_valid && (state_q != TRK_EMPTY) && step_ok;
        trig_target = in_blk + ONE_BLK;
    end

endmodule

// File: rtl/seq_pf_issuer.sv
module seq_pf_issuer
    import seq_pf_pkg::*;
#(
    parameter int BLK_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [BLK_W-1:0] trig_target,
    input  logic             probe_present,
    input  logic             pf_ready,
    output logic             probe_valid,
    output logic [BLK_W-1:0] probe_blk,
    output logic             pf_valid,
    output logic [BLK_W-1:0] pf_blk
);

    iss_state_e       state_q, state_d;
    logic [BLK_W-1:0] cand_q, cand_d;
    logic [BLK_W-1:0] sent_q, sent_d;
    logic             sent_v_q, sent_v_d;
    logic             is_dup;

    assign is_dup = sent_v_q && (cand_q == sent_q);

    // State register with candidate and last-issued record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ISS_IDLE;
            cand_q   <= '0;
            sent_q   <= '0;
            sent_v_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            cand_q   <= cand_d;
            sent_q   <= sent_d;
            sent_v_q <= sent_v_d;
        end
    end

    // Next state: triggers are taken only in ISS_IDLE.
    always_comb begin
        state_d  = state_q;
        cand_d   = cand_q;
        sent_d   = sent_q;
        sent_v_d = sent_v_q;
        unique case (state_q)
            ISS_IDLE: begin
                if (trig) begin
                    state_d = ISS_PROBE;
                    cand_d  = trig_target;
                end
            end
            ISS_PROBE: begin
                state_d = (probe_present || is_dup) ? ISS_IDLE : ISS_OFFER;
            end
            ISS_OFFER: begin
                if (pf_ready) begin
                    state_d  = ISS_IDLE;
                    sent_d   = cand_q;
                    sent_v_d = 1'b1;
                end
            end
            default: state_d = ISS_IDLE;
        endcase
    end

    // Outputs decoded from the state register.
    always_comb begin
        probe_valid = (state_q == ISS_PROBE);
        probe_blk   = cand_q;
        pf_valid    = (state_q == ISS_OFFER);
        pf_blk      = cand_q;
    end

endmodule

// File: rtl/seq_prefetch.sv
module seq_prefetch #(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              probe_valid,
    output logic [ADDR_W-1:0] probe_addr,
    input  logic              probe_present,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr
);

    localparam int BLK_W = ADDR_W - OFFS_W;

    logic             trig;
    logic [BLK_W-1:0] trig_target;
    logic [BLK_W-1:0] probe_blk;
    logic [BLK_W-1:0] pf_blk;

    seq_pf_tracker #(.BLK_W(BLK_W)) u_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (acc_valid),
        .in_blk      (acc_addr[ADDR_W-1:OFFS_W]),
        .trig        (trig),
        .trig_target (trig_target)
    );

    seq_pf_issuer #(.BLK_W(BLK_W)) u_issuer (
        .clk           (clk),
        .rst_n         (rst_n),
        .trig          (trig),
        .trig_target   (trig_target),
        .probe_present (probe_present),
        .pf_ready      (pf_ready),
        .probe_valid   (probe_valid),
        .probe_blk     (probe_blk),
        .pf_valid      (pf_valid),
        .pf_blk        (pf_blk)
    );

    assign probe_addr = {probe_blk, {OFFS_W{1'b0}}};
    assign pf_addr    = {pf_blk, {OFFS_W{1'b0}}};

endmodule

// File: rtl/seq_prefetch_chk.sv
module seq_prefetch_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              probe_valid,
    input logic              probe_present,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [ADDR_W-1:0] pf_addr
);

    // R7: a stalled offer keeps its address.
    a_r7_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));

    // R4: the probe lasts a single cycle.
    a_r4_probe_single: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid |=> !probe_valid);

    // R4: a resident block is never offered.
    a_r4_present_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid && probe_present |=> !pf_valid);

    // R6: a probe and an offer are never pending together.
    a_r6_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid |-> !pf_valid);

    // R2: a probe only follows an access.
    a_r2_probe_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(probe_valid) |-> $past(acc_valid));

    // R9: an offer starts right after a probe that found nothing.
    a_r9_offer_after_probe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_valid) |-> $past(probe_valid) && !$past(probe_present));

endmodule

bind seq_prefetch seq_prefetch_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (acc_valid),
    .probe_valid   (probe_valid),
    .probe_present (probe_present),
    .pf_valid      (pf_valid),
    .pf_ready      (pf_ready),
    .pf_addr       (pf_addr)
);

// File: tb/seq_prefetch_tb.sv
`timescale 1ns/1ps
module seq_prefetch_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        probe_valid;
    logic [31:0] probe_addr;
    logic        probe_present;
    logic        pf_valid;
    logic        pf_ready = 1'b0;
    logic [31:0] pf_addr;
    logic        filt_on = 1'b0;
    logic        done = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    int n_hs  = 0;
    logic [31:0] last_hs = '0;

    // Reference model state.
    int          m_st = 0;
    logic [27:0] m_cand = '0;
    logic [27:0] m_sent = '0;
    logic        m_sent_v = 1'b0;
    logic [27:0] m_prev = '0;
    logic        m_prev_v = 1'b0;

    always #2.5 clk = ~clk;

    // Cache model for the filter: blocks whose low nibble is 0xA are resident.
    assign probe_present = probe_valid && filt_on && (probe_addr[7:4] == 4'hA);

    seq_prefetch u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_valid     (acc_valid),
        .acc_addr      (acc_addr),
        .probe_valid   (probe_valid),
        .probe_addr    (probe_addr),
        .probe_present (probe_present),
        .pf_valid      (pf_valid),
        .pf_ready      (pf_ready),
        .pf_addr       (pf_addr)
    );

    function automatic bit model_cached(logic [27:0] b);
        return filt_on && (b[3:0] == 4'hA);
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: compare outputs, drive inputs, advance the model.
    task automatic step(bit av, logic [31:0] a, bit rdy);
        logic [27:0] blk;
        bit trig;
        @(negedge clk);
        chk(probe_valid == (m_st == 1), "R2/R4 probe_valid", 32'(probe_valid), 32'(m_st == 1));
        if (m_st == 1)
            chk(probe_addr == {m_cand, 4'h0}, "R3/R4 probe_addr", probe_addr, {m_cand, 4'h0});
        chk(pf_valid == (m_st == 2), "R5/R6/R7/R9 pf_valid", 32'(pf_valid), 32'(m_st == 2));
        if (m_st == 2)
            chk(pf_addr == {m_cand, 4'h0}, "R3/R7/R8 pf_addr", pf_addr, {m_cand, 4'h0});
        acc_valid = av;
        acc_addr  = a;
        pf_ready  = rdy;
        if (pf_valid && rdy) begin
            n_hs++;
            last_hs = pf_addr;
        end
        blk  = a[31:4];
        trig = av && m_prev_v && (blk == m_prev + 28'd1);
        case (m_st)
            0: if (trig) begin m_st = 1; m_cand = blk + 28'd1; end
            1: m_st = (model_cached(m_cand) || (m_sent_v && m_cand == m_sent)) ? 0 : 2;
            2: if (rdy) begin m_st = 0; m_sent = m_cand; m_sent_v = 1'b1; end
            default: m_st = 0;
        endcase
        if (av) begin
            m_prev   = blk;
            m_prev_v = 1'b1;
        end
    endtask

    task automatic idle(int n, bit rdy);
        for (int i = 0; i < n; i++) step(1'b0, 32'h0, rdy);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    initial begin
        int hs0;
        logic [31:0] cur;
        void'($urandom(32'd2024));
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(pf_valid == 1'b0, "R1 pf_valid in reset", 32'(pf_valid), 0);
        chk(probe_valid == 1'b0, "R1 probe_valid in reset", 32'(probe_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pf_valid == 1'b0, "R1 pf_valid after reset", 32'(pf_valid), 0);
        chk(probe_valid == 1'b0, "R1 probe_valid after reset", 32'(probe_valid), 0);

        // R2/R3: sequential run 0x48010..0x48040
        for (int i = 1; i <= 4; i++) begin
            step(1'b1, 32'h48000 + 32'(i) * 32'h10, 1'b1);
            idle(3, 1'b1);
        end
        chk(n_hs == 3, "R2 run request count", 32'(n_hs), 3);
        chk(last_hs == 32'h48050, "R3 run final target", last_hs, 32'h48050);

        // R3: offset bits ignored
        step(1'b1, 32'h12340, 1'b1);
        step(1'b1, 32'h60013, 1'b1);
        step(1'b1, 32'h6002F, 1'b1);
        idle(4, 1'b1);
        chk(last_hs == 32'h60030, "R3 offset ignored", last_hs, 32'h60030);

        // R5: repeat of last issued block is discarded
        hs0 = n_hs;
        step(1'b1, 32'h60018, 1'b1);
        step(1'b1, 32'h60020, 1'b1);
        idle(4, 1'b1);
        chk(n_hs == hs0, "R5 duplicate dropped", 32'(n_hs), 32'(hs0));

        // R4: resident target is discarded
        filt_on = 1'b1;
        step(1'b1, 32'h70080, 1'b1);
        step(1'b1, 32'h70090, 1'b1);
        idle(4, 1'b1);
        chk(n_hs == hs0, "R4 resident dropped", 32'(n_hs), 32'(hs0));
        filt_on = 1'b0;

        // R6/R7: trigger during stall is dropped, offer held
        step(1'b1, 32'h80000, 1'b0);
        step(1'b1, 32'h80010, 1'b0);
        idle(2, 1'b0);
        step(1'b1, 32'h80020, 1'b0);
        idle(3, 1'b0);
        idle(4, 1'b1);
        chk(n_hs == hs0 + 1, "R6 single request after stall", 32'(n_hs), 32'(hs0 + 1));
        chk(last_hs == 32'h80020, "R6 stalled target kept", last_hs, 32'h80020);

        // R8: wrap at top of address space
        step(1'b1, 32'hFFFFFFE0, 1'b1);
        step(1'b1, 32'hFFFFFFF0, 1'b1);
        idle(4, 1'b1);
        chk(last_hs == 32'h00000000, "R8 wrap target", last_hs, 32'h0);
        step(1'b1, 32'h00000005, 1'b1);
        idle(4, 1'b1);
        chk(last_hs == 32'h00000010, "R8 wrap step", last_hs, 32'h10);

        // Constrained random: sequential-heavy, random, mixed with filter
        cur = 32'h100000;
        for (int ph = 0; ph < 3; ph++) begin
            int seq_pct;
            seq_pct = (ph == 0) ? 90 : ((ph == 1) ? 0 : 50);
            filt_on = (ph == 2);
            for (int i = 0; i < 2000; i++) begin
                bit av;
                bit rdy;
                av  = ($urandom % 100) < 60;
                rdy = ($urandom % 100) < 70;
                if (av) begin
                    if (($urandom % 100) < seq_pct)
                        cur = ((cur & 32'hFFFFFFF0) + 32'h10) | ($urandom & 32'hF);
                    else
                        cur = $urandom;
                end
                step(av, cur, rdy);
            end
        end
        idle(4, 1'b1);
        chk(n_hs > hs0 + 10, "R2 random traffic produced requests", 32'(n_hs), 32'(hs0 + 10));

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

endmodule